// File: doc/BRIEF.md
# Partitioned SIMD Lane ALU

This block is the arithmetic slice of one 64-bit lane of a vector unit. Every cycle it may accept one operation on a 64-bit operand word. A width field set per operation splits that word into four 16-bit elements, two 32-bit elements or one 64-bit element. Each element is computed on its own: carries, borrows, products and shift sign-fill never cross an element boundary. Four copies of the slice side by side form a 256-bit datapath. Most operations need no traffic between lanes.

The operations are element-wise add, subtract and multiply (low half). Three further operations use a scalar: the multiply scales every element of A by element 0 of B broadcast to all positions, the multiply-add adds such a product to an accumulator word, and the shift moves every element right arithmetically by an amount held in B. A flag bit per element decides whether that element is written back, which gives conditional execution. The result word and a write enable per 16-bit slice are registered, one cycle after the operation is presented.

Top module: `lane_alu`

## Requirements
- R1: While reset is asserted and after its release, before any operation, `res` is zero and `wen` is zero.
- R2: An operation presented with `in_valid` high at a rising clock edge appears on `res` and `wen` right after that edge. In a cycle where `in_valid` is low, `wen` becomes zero and `res` keeps its previous value.
- R3: Width code `ew` is 0 for four 16-bit elements, 1 for two 32-bit elements and 2 for one 64-bit element. Element e occupies bits starting at e times the element width. Code 3 is reserved and yields `res` zero and `wen` zero.
- R4: Opcode 0 adds and opcode 1 subtracts (A minus B) element by element, wrapping modulo the element width. No carry or borrow reaches the neighbouring element.
- R5: Opcode 2 gives, per element, the low element-width bits of the product of the A and B elements.
- R6: Opcode 3 multiplies each element of A by element 0 of B (its lowest element at the chosen width) and keeps the low element-width bits. The other elements of B have no effect.
- R7: Opcode 4 gives, per element, the accumulator element plus the A element times element 0 of B, wrapped to the element width.
- R8: Opcode 5 shifts each element of A right arithmetically by the amount in B bits 5:0, filling with that element's own sign bit. An amount of the element width or more yields every bit equal to the sign.
- R9: `wen` bit k covers bits 16k+15:16k. It is set only when the flag of the element holding that slice is 1. Element e uses `flag` bit e: all four bits at width 16, bits 0 and 1 at width 32, bit 0 alone at width 64.
- R10: Opcodes 6 and 7 are reserved and yield `res` zero and `wen` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (see R4 to R10) |
| ew | input | 2 | Element width code (see R3) |
| src_a | input | 64 | Operand word A |
| src_b | input | 64 | Operand word B, also scalar source and shift amount |
| acc | input | 64 | Accumulator word for multiply-add |
| flag | input | 4 | Per-element write flags |
| res | output | 64 | Registered result word |
| wen | output | 4 | Registered write enable per 16-bit slice |

## Verification
Two of the block's functions meet in the same cycle when an element wraps at its boundary while the flag of the neighbouring element is clear. The partition then has to stop the carry, and the mask has to suppress the neighbour's write, both on one result. The bench provokes this with all-ones plus one at each width under mixed flag patterns. It also sends random words with random flags and widths through a behavioural element-by-element model, comparing `res` and `wen` every cycle. A broadcast multiply-add whose accumulator overflows in one element while a masked element beside it is zero is judged the same way.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_MULS  = 3'd3,
        OP_MADDS = 3'd4,
        OP_SRAS  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } lane_op_e;

    typedef enum logic [1:0] {
        EW_16  = 2'd0,
        EW_32  = 2'd1,
        EW_64  = 2'd2,
        EW_RSV = 2'd3
    } lane_ew_e;

endpackage

// File: rtl/lane_addsub.sv
// Slice-chained adder whose carry is cut at every element start.
module lane_addsub #(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input  logic [NSLICE*SLICE_W-1:0] x,
    input  logic [NSLICE*SLICE_W-1:0] y,
    input  logic                      sub,
    input  logic [NSLICE-1:0]         seg_start,
    output logic [NSLICE*SLICE_W-1:0] sum
);
    logic [NSLICE-1:0] cin;
    logic [NSLICE-1:0] cout;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        logic [SLICE_W-1:0] yk;
        assign yk = y[k*SLICE_W +: SLICE_W] ^ {SLICE_W{sub}};

        if (k == 0) begin : g_first
            assign cin[k] = sub;
        end else begin : g_rest
            assign cin[k] = seg_start[k] ? sub : cout[k-1];
        end

        if (k < NSLICE - 1) begin : g_carry
            logic [SLICE_W:0] part;
            assign part = {1'b0, x[k*SLICE_W +: SLICE_W]} + {1'b0, yk}
                        + {{SLICE_W{1'b0}}, cin[k]};
            assign sum[k*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            assign cout[k] = part[SLICE_W];
        end else begin : g_top
            assign sum[k*SLICE_W +: SLICE_W] = x[k*SLICE_W +: SLICE_W] + yk
                                             + {{(SLICE_W-1){1'b0}}, cin[k]};
            assign cout[k] = 1'b0;
        end
    end
endmodule

// File: rtl/lane_mul.sv
// Low-half multiply at each element width, selected by width code.
module lane_mul
    import lane_alu_pkg::*;
#(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input  logic [NSLICE*SLICE_W-1:0] x,
    input  logic [NSLICE*SLICE_W-1:0] y,
    input  lane_ew_e                  ew,
    output logic [NSLICE*SLICE_W-1:0] prod
);
    localparam int W    = NSLICE * SLICE_W;
    localparam int DW   = 2 * SLICE_W;
    localparam int NDBL = NSLICE / 2;

    logic [W-1:0] p_s;
    logic [W-1:0] p_d;
    logic [W-1:0] p_w;

    for (genvar k = 0; k < NSLICE; k++) begin : g_s
        assign p_s[k*SLICE_W +: SLICE_W] = x[k*SLICE_W +: SLICE_W] * y[k*SLICE_W +: SLICE_W];
    end

    for (genvar k = 0; k < NDBL; k++) begin : g_d
        assign p_d[k*DW +: DW] = x[k*DW +: DW] * y[k*DW +: DW];
    end

    assign p_w = x * y;

    always_comb begin
        unique case (ew)
            EW_16:   prod = p_s;
            EW_32:   prod = p_d;
            default: prod = p_w;
        endcase
    end
endmodule

// File: rtl/lane_sra.sv
// Arithmetic right shift per element with sign fill and amount clamp.
module lane_sra
    import lane_alu_pkg::*;
#(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input  logic [NSLICE*SLICE_W-1:0]         x,
    input  logic [$clog2(NSLICE*SLICE_W)-1:0] amt,
    input  lane_ew_e                          ew,
    output logic [NSLICE*SLICE_W-1:0]         y
);
    localparam int W    = NSLICE * SLICE_W;
    localparam int AW   = $clog2(W);
    localparam int DW   = 2 * SLICE_W;
    localparam int NDBL = NSLICE / 2;

    logic [AW-1:0] amt_s;
    logic [AW-1:0] amt_d;
    logic [W-1:0]  y_s;
    logic [W-1:0]  y_d;
    logic [W-1:0]  y_w;

    assign amt_s = (amt >= AW'(SLICE_W)) ? AW'(SLICE_W - 1) : amt;
    assign amt_d = (amt >= AW'(DW))      ? AW'(DW - 1)      : amt;

    for (genvar k = 0; k < NSLICE; k++) begin : g_s
        assign y_s[k*SLICE_W +: SLICE_W] = $signed(x[k*SLICE_W +: SLICE_W]) >>> amt_s;
    end

    for (genvar k = 0; k < NDBL; k++) begin : g_d
        assign y_d[k*DW +: DW] = $signed(x[k*DW +: DW]) >>> amt_d;
    end

    assign y_w = $signed(x) >>> amt;

    always_comb begin
        unique case (ew)
            EW_16:   y = y_s;
            EW_32:   y = y_d;
            default: y = y_w;
        endcase
    end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
    import lane_alu_pkg::*;
#(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [2:0]                op,
    input  logic [1:0]                ew,
    input  logic [NSLICE*SLICE_W-1:0] src_a,
    input  logic [NSLICE*SLICE_W-1:0] src_b,
    input  logic [NSLICE*SLICE_W-1:0] acc,
    input  logic [NSLICE-1:0]         flag,
    output logic [NSLICE*SLICE_W-1:0] res,
    output logic [NSLICE-1:0]         wen
);
    localparam int W    = NSLICE * SLICE_W;
    localparam int AW   = $clog2(W);
    localparam int DW   = 2 * SLICE_W;
    localparam int NDBL = NSLICE / 2;

    lane_op_e          opc;
    lane_ew_e          ewc;
    logic [NSLICE-1:0] seg_start;
    logic [W-1:0]      bcast;
    logic [W-1:0]      mul_y;
    logic [W-1:0]      add_x;
    logic [W-1:0]      add_y;
    logic [W-1:0]      sum;
    logic [W-1:0]      prod;
    logic [W-1:0]      shr;
    logic [W-1:0]      res_d;
    logic [NSLICE-1:0] wen_d;
    logic              legal_op;
    logic              legal_w;
    logic              use_scalar;

    assign opc = lane_op_e'(op);
    assign ewc = lane_ew_e'(ew);

    // element starts at slice k
    for (genvar k = 0; k < NSLICE; k++) begin : g_seg
        assign seg_start[k] = (k == 0) || (ewc == EW_16) || ((ewc == EW_32) && (k % 2 == 0));
    end

    // scalar broadcast of element 0 of B
    always_comb begin
        unique case (ewc)
            EW_16:   bcast = {NSLICE{src_b[SLICE_W-1:0]}};
            EW_32:   bcast = {NDBL{src_b[DW-1:0]}};
            default: bcast = src_b;
        endcase
    end

    assign use_scalar = (opc == OP_MULS) || (opc == OP_MADDS);
    assign mul_y      = use_scalar ? bcast : src_b;
    assign add_x      = (opc == OP_MADDS) ? acc  : src_a;
    assign add_y      = (opc == OP_MADDS) ? prod : src_b;

    lane_mul #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_mul (
        .x    (src_a),
        .y    (mul_y),
        .ew   (ewc),
        .prod (prod)
    );

    lane_addsub #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_add (
        .x         (add_x),
        .y         (add_y),
        .sub       (opc == OP_SUB),
        .seg_start (seg_start),
        .sum       (sum)
    );

    lane_sra #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_sra (
        .x   (src_a),
        .amt (src_b[AW-1:0]),
        .ew  (ewc),
        .y   (shr)
    );

    assign legal_w = (ewc != EW_RSV);

    always_comb begin
        legal_op = 1'b1;
        res_d    = '0;
        unique case (opc)
            OP_ADD, OP_SUB, OP_MADDS: res_d = sum;
            OP_MUL, OP_MULS:          res_d = prod;
            OP_SRAS:                  res_d = shr;
            default:                  legal_op = 1'b0;
        endcase
        if (!legal_w) res_d = '0;
    end

    // slice write enable from the flag of its element
    for (genvar k = 0; k < NSLICE; k++) begin : g_wen
        logic fk;
        always_comb begin
            unique case (ewc)
                EW_16:   fk = flag[k];
                EW_32:   fk = flag[k/2];
                default: fk = flag[0];
            endcase
        end
        assign wen_d[k] = in_valid && legal_op && legal_w && fk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
            wen <= '0;
        end else begin
            wen <= wen_d;
            if (in_valid) res <= res_d;
        end
    end
endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [2:0]                op,
    input logic [1:0]                ew,
    input logic [NSLICE*SLICE_W-1:0] src_a,
    input logic [NSLICE*SLICE_W-1:0] src_b,
    input logic [NSLICE*SLICE_W-1:0] acc,
    input logic [NSLICE-1:0]         flag,
    input logic [NSLICE*SLICE_W-1:0] res,
    input logic [NSLICE-1:0]         wen
);
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (wen == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res)); // R2

    AST_RSV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ew == 2'd3) |=> (wen == '0 && res == '0)); // R3

    AST_RSV_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 3'd6) |=> (wen == '0)); // R10

    AST_PAIR_W32: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ew == 2'd1) |=> (wen[0] == wen[1] && wen[2] == wen[3])); // R9

    AST_WHOLE_W64: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ew == 2'd2) |=> ($countones(wen) == 0 || $countones(wen) == NSLICE)); // R9

    AST_FLAG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ew == 2'd0) |=> ((wen & ~$past(flag)) == '0)); // R9

    AST_CARRY_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0 && ew == 2'd0) |=>
        (res[2*SLICE_W-1:SLICE_W] == $past(src_a[2*SLICE_W-1:SLICE_W] + src_b[2*SLICE_W-1:SLICE_W]))); // R4
endmodule

bind lane_alu lane_alu_chk #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_chk (.*);

// File: tb/tb_lane_alu.sv
module tb_lane_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  ew = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] acc = '0;
    logic [3:0]  flag = '0;
    logic [63:0] res;
    logic [3:0]  wen;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] exp_res = '0;
    logic [3:0]  exp_wen = '0;

    always #2 clk = ~clk;

    lane_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ew(ew),
        .src_a(src_a), .src_b(src_b), .acc(acc), .flag(flag),
        .res(res), .wen(wen)
    );

    // behavioural element model: returns {res, wen}
    function automatic logic [67:0] model(input logic v, input logic [2:0] o,
        input logic [1:0] w, input logic [63:0] a, input logic [63:0] b,
        input logic [63:0] c, input logic [3:0] fl, input logic [63:0] prev);
        logic [63:0] out, mask, ae, be, ce, bs, r, sx;
        logic [3:0]  we;
        int wd, ne, amt, spe;
        if (!v) return {prev, 4'b0};
        if (w == 2'd3 || o > 3'd5) return {64'd0, 4'b0};
        wd   = (w == 2'd0) ? 16 : (w == 2'd1) ? 32 : 64;
        ne   = 64 / wd;
        spe  = wd / 16;
        mask = (wd == 64) ? '1 : ((64'd1 << wd) - 64'd1);
        bs   = b & mask;
        out  = '0;
        we   = '0;
        for (int e = 0; e < ne; e++) begin
            ae = (a >> (e*wd)) & mask;
            be = (b >> (e*wd)) & mask;
            ce = (c >> (e*wd)) & mask;
            case (o)
                3'd0: r = ae + be;
                3'd1: r = ae - be;
                3'd2: r = ae * be;
                3'd3: r = ae * bs;
                3'd4: r = ce + ae * bs;
                default: begin
                    amt = int'(b[5:0]);
                    if (amt > wd - 1) amt = wd - 1;
                    sx = (((ae >> (wd-1)) & 64'd1) != 0) ? (ae | ~mask) : ae;
                    r  = $signed(sx) >>> amt;
                end
            endcase
            out = out | ((r & mask) << (e*wd));
            for (int j = 0; j < spe; j++) we[e*spe + j] = fl[e];
        end
        return {out, we};
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (res !== exp_res || wen !== exp_wen) begin
            n_fail++;
            $display("FAIL %s: res=%h wen=%b expected res=%h wen=%b",
                     tag, res, wen, exp_res, exp_wen);
        end
    endtask

    // drive at negedge, check at the following negedge
    task automatic step(input logic v, input logic [2:0] o, input logic [1:0] w,
        input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
        input logic [3:0] fl, input string tag);
        logic [67:0] m;
        in_valid = v; op = o; ew = w; src_a = a; src_b = b; acc = c; flag = fl;
        m = model(v, o, w, a, b, c, fl, exp_res);
        @(posedge clk);
        @(negedge clk);
        exp_res = m[67:4];
        exp_wen = m[3:0];
        check(tag);
    endtask

    function automatic string tag_of(input logic v, input logic [2:0] o, input logic [1:0] w);
        if (!v) return "R2";
        if (w == 2'd3) return "R3";
        case (o)
            3'd0, 3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R4 carry cut at each width, and a carry that crosses slices at 64
        step(1, 3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 0, 4'hF, "R4");
        step(1, 3'd0, 2'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0001, 0, 4'hF, "R4");
        step(1, 3'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 4'h1, "R4");
        step(1, 3'd1, 2'd0, 64'h0, 64'h0001_0001_0001_0001, 0, 4'hF, "R4");
        step(1, 3'd1, 2'd1, 64'h0000_0005_0000_0000, 64'h0000_0001_0000_0001, 0, 4'h3, "R4");
        // R5 wrap of the product
        step(1, 3'd2, 2'd0, 64'h8000_0003_FFFF_0100, 64'h0002_0005_FFFF_0100, 0, 4'hF, "R5");
        step(1, 3'd2, 2'd1, 64'h8000_0000_0001_0000, 64'h0000_0002_0001_0000, 0, 4'h3, "R5");
        // R6 broadcast ignores upper elements of B
        step(1, 3'd3, 2'd1, 64'h0000_0003_0000_0007, 64'hDEAD_BEEF_0000_0010, 0, 4'h3, "R6");
        step(1, 3'd3, 2'd0, 64'h0004_0003_0002_0001, 64'h1234_5678_9ABC_0003, 0, 4'hF, "R6");
        // R7 accumulate with overflow beside a masked element
        step(1, 3'd4, 2'd0, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0002,
             64'hFFFF_0000_FFFE_0010, 4'b1101, "R7");
        step(1, 3'd4, 2'd2, 64'h3, 64'h5, 64'h10, 4'h1, "R7");
        // R8 sign fill per element and clamp
        step(1, 3'd5, 2'd0, 64'h8000_7FFF_F000_0100, 64'd4, 0, 4'hF, "R8");
        step(1, 3'd5, 2'd0, 64'h8000_7FFF_F000_0100, 64'd20, 0, 4'hF, "R8");
        step(1, 3'd5, 2'd1, 64'h7FFF_FFFF_8000_0000, 64'd40, 0, 4'h3, "R8");
        step(1, 3'd5, 2'd2, 64'h8000_0000_0000_0000, 64'd63, 0, 4'h1, "R8");
        // R9 flag mapping
        step(1, 3'd0, 2'd0, 64'h1, 64'h1, 0, 4'b0101, "R9");
        step(1, 3'd0, 2'd1, 64'h1, 64'h1, 0, 4'b1110, "R9");
        step(1, 3'd0, 2'd2, 64'h1, 64'h1, 0, 4'b1110, "R9");
        // R2 idle hold, R10 reserved op, R3 reserved width
        step(0, 3'd0, 2'd0, 64'h5, 64'h5, 0, 4'hF, "R2");
        step(1, 3'd6, 2'd0, 64'h5, 64'h5, 0, 4'hF, "R10");
        step(1, 3'd7, 2'd1, 64'h5, 64'h5, 0, 4'hF, "R10");
        step(1, 3'd0, 2'd3, 64'h5, 64'h5, 0, 4'hF, "R3");

        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [2:0] o;
            logic [1:0] w;
            v = ($urandom % 8) != 0;
            o = 3'($urandom % 8);
            w = 2'($urandom % 4);
            step(v, o, w, {$urandom, $urandom}, {$urandom, $urandom},
                 {$urandom, $urandom}, 4'($urandom), tag_of(v, o, w));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule